// File: doc/BRIEF.md
# Clock Ratio Controller

This block owns a 16-bit frequency control register and turns its three 3-bit divider codes into clock-enable strobes for the CPU, bus and peripheral domains. It runs on the fast PLL-output clock. Each domain asserts a registered one-cycle enable every N cycles, where N is decoded from that domain's code. Downstream logic gates its flops with these enables instead of switching clocks.

The block also reports the effective PLL multiplier. This value depends on a static 3-bit clock-mode strap, a chip-variant select and the PLL1 enable bit. It is given in half units because one mode combination yields a multiplier of one half.

Software reaches the register through a simple request/write-enable bus that carries an access size code. Only 16-bit accesses at the register offset have any effect. On leaving reset, the register takes a value chosen by the strap and the variant.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: The register sits at offset 0. Bits 2:0 hold the peripheral code, bits 5:3 the bus code and bits 8:6 the CPU code. Bit 9 is PLL2 enable, bit 10 is PLL1 enable and bit 11 is clock-out enable. A read with size code 1 (16-bit) at offset 0 returns the register value, and a 16-bit write there stores the write data.
- R2: After reset the register reads back a value selected by the mode strap:
  - mode 0: 0x0E1A
  - mode 1: 0x0E23, or 0x0E2C when the enhanced variant is selected
  - modes 2 and 3: 0x0E13
  - modes 4 and 5: 0x0E0A
  - mode 6: 0x0808
  - mode 7: treated as mode 6
- R3: CPU and bus divide ratios for codes 0 to 7 are 1, 2, 3, 4, 6, 8, 10 and 12.
- R4: Peripheral divide ratios for codes 0 to 7 are 2, 3, 4, 6, 8, 10, 12 and 14.
- R5: Strobe timing:
  - While reset is held, all strobes are low.
  - Every strobe is high in the first cycle after reset is released.
  - Each strobe then repeats every ratio cycles.
  - A ratio of 1 keeps the strobe high on every cycle.
- R6: A ratio change completes the running period and takes effect from the next strobe. No shortened period is produced.
- R7: Base variant (variant select 0): the multiplier output, in half units, is 12 when PLL1 is enabled and 2 when it is not. In modes 3, 5, 6 and 7 the value is halved.
- R8: Enhanced variant (variant select 1): the multiplier output, in half units, is 24 in modes 0, 1, 3 and 5, and 12 in modes 2, 4, 6 and 7. It is 2 whenever PLL1 is disabled.
- R9: Accesses that have no effect:
  - A read with size code 0 (byte), 2 (32-bit) or 3, or at any other offset, returns 0xFFFF.
  - Such writes leave the register unchanged.
  - The read data is also 0xFFFF when no read is requested.
- R10: A stored write whose data differs from the register in bit 9 or bit 10 sets a sticky PLL-change flag. The data is still stored, and the flag clears only on reset.
- R11: The clock-out enable output follows register bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast PLL-output clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Static clock-mode strap |
| enh_i | input | 1 | Variant select, 1 = enhanced |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| size_i | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |
| cpu_stb_o | output | 1 | CPU domain clock enable |
| bus_stb_o | output | 1 | Bus domain clock enable |
| per_stb_o | output | 1 | Peripheral domain clock enable |
| pll_mul_x2_o | output | 5 | Effective PLL multiplier in half units |
| pll_chg_o | output | 1 | Sticky PLL-change flag |
| clkout_en_o | output | 1 | Clock-out enable |

## Verification
The hardest case to reach from the ports is a ratio change that lands in the middle of a long period. The write must arrive just after a strobe and must not truncate the period already running.

The stimulus first programs the peripheral code for a ratio of 14. It waits for a strobe, then writes a ratio of 2 within the next two cycles. It measures the next two intervals, which must be 14 and then 2.

A reference model built on integer counters is compared against the design on every clock. This comparison covers a sweep of all eight codes in every domain, written at arbitrary points in the period.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int CFG_W    = 16;
  localparam int CODE_W   = 3;
  localparam int RATIO_W  = 4;
  localparam int MUL_W    = 5;
  localparam int NUM_DOM  = 3;
  localparam int PLL2_BIT = 9;
  localparam int PLL1_BIT = 10;
  localparam int CKO_BIT  = 11;
  localparam logic [CFG_W-1:0] PLL_MASK = (CFG_W'(1) << PLL2_BIT) | (CFG_W'(1) << PLL1_BIT);

  // cpu/bus: code+1 below 4, else (code-1)*2
  function automatic logic [RATIO_W-1:0] core_ratio(input logic [CODE_W-1:0] c);
    logic [RATIO_W-1:0] w;
    w = RATIO_W'(c);
    return (c < CODE_W'(4)) ? w + RATIO_W'(1) : (w - RATIO_W'(1)) << 1;
  endfunction

  // peripheral: code+2 below 3, else code*2
  function automatic logic [RATIO_W-1:0] per_ratio(input logic [CODE_W-1:0] c);
    logic [RATIO_W-1:0] w;
    w = RATIO_W'(c);
    return (c < CODE_W'(3)) ? w + RATIO_W'(2) : w << 1;
  endfunction

  function automatic logic [2:0] clamp_mode(input logic [2:0] m);
    return (m == 3'd7) ? 3'd6 : m;
  endfunction

  function automatic logic [CFG_W-1:0] reset_cfg(input logic [2:0] m, input logic enh);
    case (clamp_mode(m))
      3'd0:       return 16'h0E1A;
      3'd1:       return enh ? 16'h0E2C : 16'h0E23;
      3'd2, 3'd3: return 16'h0E13;
      3'd4, 3'd5: return 16'h0E0A;
      default:    return 16'h0808;
    endcase
  endfunction

endpackage

// File: rtl/clk_ratio_mul.sv
module clk_ratio_mul
  import clk_ratio_pkg::*;
(
  input  logic [2:0]       mode_i,
  input  logic             enh_i,
  input  logic             pll1_i,
  output logic [MUL_W-1:0] mul_x2_o
);

  logic [2:0]       m;
  logic             halve;
  logic             low_mul;
  logic [MUL_W-1:0] base_x2;
  logic [MUL_W-1:0] enh_x2;

  always_comb begin
    m       = clamp_mode(mode_i);
    halve   = (m == 3'd3) || (m == 3'd5) || (m == 3'd6);
    low_mul = (m == 3'd2) || (m == 3'd4) || (m == 3'd6);
    base_x2 = pll1_i ? MUL_W'(12) : MUL_W'(2);
    if (halve) base_x2 = base_x2 >> 1;
    if (!pll1_i)      enh_x2 = MUL_W'(2);
    else if (low_mul) enh_x2 = MUL_W'(12);
    else              enh_x2 = MUL_W'(24);
    mul_x2_o = enh_i ? enh_x2 : base_x2;
  end

endmodule

// File: rtl/clk_ratio_regs.sv
module clk_ratio_regs
  import clk_ratio_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int REG_OFS = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              enh_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [CFG_W-1:0]  wdata_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [CFG_W-1:0]  rdata_o,
  output logic              chg_o
);

  logic [CFG_W-1:0] cfg_q;
  logic             init_q;
  logic             chg_q;
  logic             hit;
  logic             wr_ok;
  logic             rd_ok;

  // straps are static: until the first edge the reset value is decoded live
  assign cfg_o = init_q ? cfg_q : reset_cfg(mode_i, enh_i);
  assign hit   = req_i && (addr_i == ADDR_W'(REG_OFS)) && (acc_size_e'(size_i) == SZ_HALF);
  assign wr_ok = hit && we_i;
  assign rd_ok = hit && !we_i;

  assign rdata_o = rd_ok ? cfg_o : '1;
  assign chg_o   = chg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      init_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      init_q <= 1'b1;
      if (wr_ok) begin
        cfg_q <= wdata_i;
        if (|((cfg_o ^ wdata_i) & PLL_MASK)) chg_q <= 1'b1;
      end else if (!init_q) begin
        cfg_q <= cfg_o;
      end
    end
  end

  AST_CHG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |=> chg_q); // R10

  AST_WRITE_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> (cfg_o == $past(wdata_i))); // R1

  AST_BAD_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && req_i && we_i && acc_size_e'(size_i) != SZ_HALF) |=> $stable(cfg_o)); // R9

  AST_BAD_READ_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && acc_size_e'(size_i) != SZ_HALF) |-> (rdata_o == '1)); // R9

endmodule

// File: rtl/clk_ratio_strobe.sv
module clk_ratio_strobe #(
  parameter int RATIO_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               strobe_o
);

  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] ratio_eff;
  logic               stb_q;

  assign ratio_eff = (ratio_i == '0) ? RATIO_W'(1) : ratio_i;
  assign strobe_o  = stb_q;

  // ratio sampled only at a boundary, so a running period always completes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= RATIO_W'(1);
      stb_q   <= 1'b0;
    end else if (cnt_q == '0) begin
      stb_q   <= 1'b1;
      cnt_q   <= ratio_eff - RATIO_W'(1);
      ratio_q <= ratio_eff;
    end else begin
      stb_q   <= 1'b0;
      cnt_q   <= cnt_q - RATIO_W'(1);
    end
  end

  AST_UNIT_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_q && ratio_q == RATIO_W'(1)) |=> stb_q); // R5

  AST_STROBE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_q && ratio_q > RATIO_W'(1)) |=> !stb_q); // R6

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q); // R5

endmodule

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
  import clk_ratio_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int REG_OFS = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              enh_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              cpu_stb_o,
  output logic              bus_stb_o,
  output logic              per_stb_o,
  output logic [4:0]        pll_mul_x2_o,
  output logic              pll_chg_o,
  output logic              clkout_en_o
);

  logic [CFG_W-1:0]   cfg;
  logic [NUM_DOM-1:0] stb;
  logic               unused_cfg;

  clk_ratio_regs #(
    .ADDR_W  (ADDR_W),
    .REG_OFS (REG_OFS)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .enh_i   (enh_i),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .size_i  (size_i),
    .wdata_i (wdata_i),
    .cfg_o   (cfg),
    .rdata_o (rdata_o),
    .chg_o   (pll_chg_o)
  );

  // domain 0 cpu (8:6), 1 bus (5:3), 2 peripheral (2:0)
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    localparam int LSB = (NUM_DOM - 1 - d) * CODE_W;
    logic [CODE_W-1:0]  code;
    logic [RATIO_W-1:0] ratio;
    assign code = cfg[LSB +: CODE_W];
    if (d == NUM_DOM - 1) begin : g_per
      assign ratio = per_ratio(code);
    end else begin : g_core
      assign ratio = core_ratio(code);
    end
    clk_ratio_strobe #(.RATIO_W(RATIO_W)) u_stb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ratio_i  (ratio),
      .strobe_o (stb[d])
    );
  end

  assign cpu_stb_o = stb[0];
  assign bus_stb_o = stb[1];
  assign per_stb_o = stb[2];

  clk_ratio_mul u_mul (
    .mode_i   (mode_i),
    .enh_i    (enh_i),
    .pll1_i   (cfg[PLL1_BIT]),
    .mul_x2_o (pll_mul_x2_o)
  );

  assign clkout_en_o = cfg[CKO_BIT];
  assign unused_cfg  = ^{cfg[CFG_W-1:CKO_BIT+1], cfg[PLL2_BIT]};

  AST_MUL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_mul_x2_o inside {5'd1, 5'd2, 5'd6, 5'd12, 5'd24}); // R7 R8

  AST_STROBE_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |=> (stb == '1)); // R5

endmodule

// File: tb/sim_clk_ratio_ctrl.sv
module sim_clk_ratio_ctrl;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        enh = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'd0;
  logic [1:0]  size = 2'd1;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        cpu_stb, bus_stb, per_stb, chg, cko;
  logic [4:0]  mul;

  always #4 clk = ~clk;

  clk_ratio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .enh_i(enh),
    .req_i(req), .we_i(we), .addr_i(addr), .size_i(size), .wdata_i(wdata),
    .rdata_o(rdata), .cpu_stb_o(cpu_stb), .bus_stb_o(bus_stb), .per_stb_o(per_stb),
    .pll_mul_x2_o(mul), .pll_chg_o(chg), .clkout_en_o(cko)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic int f_core(input int c);
    case (c)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;
      4: return 6;  5: return 8;  6: return 10; default: return 12;
    endcase
  endfunction

  function automatic int f_per(input int c);
    case (c)
      0: return 2;  1: return 3;  2: return 4;  3: return 6;
      4: return 8;  5: return 10; 6: return 12; default: return 14;
    endcase
  endfunction

  function automatic logic [15:0] f_rst(input int md, input bit e);
    case (md)
      0: return 16'h0E1A;
      1: return e ? 16'h0E2C : 16'h0E23;
      2, 3: return 16'h0E13;
      4, 5: return 16'h0E0A;
      default: return 16'h0808;
    endcase
  endfunction

  function automatic int f_mul(input int md, input bit e, input bit p1);
    if (e) begin
      if (!p1) return 2;
      if (md == 2 || md == 4 || md >= 6) return 12;
      return 24;
    end
    if (md == 3 || md == 5 || md >= 6) return p1 ? 6 : 1;
    return p1 ? 12 : 2;
  endfunction

  logic [15:0] m_cfg = 16'd0;
  bit          m_init = 1'b0;
  bit          m_flag = 1'b0;
  int          m_cnt [3] = '{0, 0, 0};
  bit          m_stb [3] = '{0, 0, 0};

  function automatic logic [15:0] m_eff();
    return m_init ? m_cfg : f_rst(int'(mode), enh);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cfg = 16'd0; m_init = 1'b0; m_flag = 1'b0;
      for (int d = 0; d < 3; d++) begin m_cnt[d] = 0; m_stb[d] = 1'b0; end
    end else begin
      logic [15:0] e;
      e = m_eff();
      for (int d = 0; d < 3; d++) begin
        int code, r;
        code = (d == 0) ? int'(e[8:6]) : (d == 1) ? int'(e[5:3]) : int'(e[2:0]);
        r = (d == 2) ? f_per(code) : f_core(code);
        if (m_cnt[d] == 0) begin m_stb[d] = 1'b1; m_cnt[d] = r - 1; end
        else begin m_stb[d] = 1'b0; m_cnt[d] = m_cnt[d] - 1; end
      end
      if (req && we && addr == 8'd0 && size == 2'd1) begin
        if (((e ^ wdata) & 16'h0600) != 16'd0) m_flag = 1'b1;
        m_cfg = wdata;
      end else begin
        m_cfg = e;
      end
      m_init = 1'b1;
    end
  end

  always @(posedge clk) cyc++;

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_ni && cmp_on) begin
      logic [15:0] e, exp_rd;
      e = m_eff();
      exp_rd = (req && !we && addr == 8'd0 && size == 2'd1) ? e : 16'hFFFF;
      chk("R3 cpu strobe", cpu_stb, m_stb[0]);
      chk("R3 bus strobe", bus_stb, m_stb[1]);
      chk("R4 peripheral strobe", per_stb, m_stb[2]);
      chk("R7 R8 multiplier", mul, f_mul(int'(mode), enh, e[10]));
      chk("R10 change flag", chg, m_flag);
      chk("R11 clock out enable", cko, e[11]);
      chk("R9 read data", rdata, exp_rd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_reset(input int md, input bit e);
    rst_ni = 1'b0; mode = 3'(md); enh = e; req = 1'b0; we = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 strobes low in reset", {cpu_stb, bus_stb, per_stb}, 3'b000);
    chk("R10 flag clear in reset", chg, 1'b0);
    rst_ni = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    chk("R5 first strobe after reset", {cpu_stb, bus_stb, per_stb}, 3'b111);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [1:0] s, input logic [15:0] d);
    @(posedge clk); #2;
    req = 1'b1; we = 1'b1; addr = a; size = s; wdata = d;
    @(posedge clk); #2;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [1:0] s, input logic [15:0] exp,
                        input string tag);
    @(posedge clk); #2;
    req = 1'b1; we = 1'b0; addr = a; size = s;
    @(negedge clk);
    chk(tag, rdata, exp);
    #1 req = 1'b0;
  endtask

  task automatic wait_per();
    do @(negedge clk); while (!per_stb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int t0, t1, t2;
    // R2 R7 R8: reset values and multipliers over all straps
    for (int v = 0; v < 2; v++) begin
      for (int md = 0; md < 8; md++) begin
        do_reset(md, v[0]);
        bus_rd(8'd0, 2'd1, f_rst(md, v[0]), "R2 reset value");
        if (v == 0) chk("R7 base multiplier", mul, f_mul(md, 1'b0, f_rst(md, 1'b0)[10]));
        else        chk("R8 enhanced multiplier", mul, f_mul(md, 1'b1, f_rst(md, 1'b1)[10]));
        repeat (30) @(negedge clk);
      end
    end

    // R1 R3 R4: sweep all codes, no PLL bit change
    do_reset(5, 1'b0);
    for (int c = 0; c < 8; c++) begin
      logic [15:0] d;
      d = 16'h0E00 | 16'(c << 6) | 16'(((c + 3) % 8) << 3) | 16'((7 - c));
      bus_wr(8'd0, 2'd1, d);
      bus_rd(8'd0, 2'd1, d, "R1 register readback");
      repeat (40) @(negedge clk);
    end
    chk("R10 no flag without PLL change", chg, 1'b0);

    // R5: ratio 1 on cpu gives a strobe every cycle
    bus_wr(8'd0, 2'd1, 16'h0E00);
    repeat (20) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      chk("R5 ratio one continuous", cpu_stb, 1'b1);
      @(negedge clk);
    end

    // R6: long period completes, new ratio from the following strobe
    bus_wr(8'd0, 2'd1, 16'h0E07);
    wait_per(); wait_per();
    t0 = cyc;
    bus_wr(8'd0, 2'd1, 16'h0E00);
    wait_per(); t1 = cyc;
    wait_per(); t2 = cyc;
    chk("R6 running period kept", t1 - t0, 14);
    chk("R6 new period applied", t2 - t1, 2);

    // R9: ignored accesses
    bus_wr(8'd0, 2'd0, 16'h0E3F);
    bus_rd(8'd0, 2'd1, 16'h0E00, "R9 byte write ignored");
    bus_wr(8'd0, 2'd2, 16'h0E3F);
    bus_rd(8'd0, 2'd1, 16'h0E00, "R9 word write ignored");
    bus_wr(8'd4, 2'd1, 16'h0E3F);
    bus_rd(8'd0, 2'd1, 16'h0E00, "R9 other offset write ignored");
    bus_rd(8'd0, 2'd0, 16'hFFFF, "R9 byte read");
    bus_rd(8'd0, 2'd2, 16'hFFFF, "R9 word read");
    bus_rd(8'd4, 2'd1, 16'hFFFF, "R9 other offset read");
    chk("R10 ignored write no flag", chg, 1'b0);

    // R10 R7: PLL1 off sets flag, value stored, mode 5 halves
    bus_wr(8'd0, 2'd1, 16'h0A0A);
    @(negedge clk);
    chk("R10 flag set", chg, 1'b1);
    chk("R7 base halved pll off", mul, 5'd1);
    bus_rd(8'd0, 2'd1, 16'h0A0A, "R10 value still stored");
    bus_wr(8'd0, 2'd1, 16'h0A00);
    repeat (5) @(negedge clk);
    chk("R10 flag sticky", chg, 1'b1);

    // R11: clock-out enable follows bit 11
    bus_wr(8'd0, 2'd1, 16'h0200);
    @(negedge clk);
    chk("R11 clock out off", cko, 1'b0);
    bus_wr(8'd0, 2'd1, 16'h0A00);
    @(negedge clk);
    chk("R11 clock out on", cko, 1'b1);

    // R10 bit 9 only, R8 PLL1 off on enhanced
    do_reset(1, 1'b1);
    bus_wr(8'd0, 2'd1, 16'h0C2C);
    @(negedge clk);
    chk("R10 flag on PLL2 change", chg, 1'b1);
    chk("R8 enhanced pll on", mul, 5'd24);
    bus_wr(8'd0, 2'd1, 16'h082C);
    @(negedge clk);
    chk("R8 enhanced pll off", mul, 5'd2);
    repeat (20) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule